// File: doc/BRIEF.md
# Serial EEPROM Hub Configuration Loader

After reset, and whenever it receives a start pulse, this block fetches a short configuration image from an external three-wire serial EEPROM. The image holds a vendor identifier, a product identifier, a downstream port count and a removable-device mask. The block frames one READ command per word, shifts in the sixteen returned bits, and keeps a running byte sum. At the end of the load it either publishes the loaded record or falls back to built-in defaults.

The image is accepted only when its eight bytes sum to zero modulo 256. A data-out line that reads high on every sampled bit means no EEPROM is fitted. The amber LED pins share wires with the EEPROM interface, so the amber enable output stays low during a load and whenever an EEPROM answered. All serial timing is built from whole system-clock cycles set by parameters. The default values meet the EEPROM's minimum phase, setup and hold times at a 12 MHz core clock.

The controller has six states:
- `ST_IDLE`: waits for `start`, then goes to `ST_SEL_SETUP`.
- `ST_SEL_SETUP`: select is high and the clock is low; after the setup count it goes to `ST_BIT_LOW`.
- `ST_BIT_LOW`: the clock is low and the next command bit is on data-in; after the low count it goes to `ST_BIT_HIGH`.
- `ST_BIT_HIGH`: the clock is high; the returned bit is captured in its last cycle. It then goes back to `ST_BIT_LOW`, or to `ST_SEL_HOLD` after the 25th bit.
- `ST_SEL_HOLD`: select stays high after the last clock; after the hold count it goes to `ST_SEL_GAP`.
- `ST_SEL_GAP`: select is low between words. It goes to `ST_SEL_SETUP` for the next word, or to `ST_IDLE` after the fourth word, setting `done`.

Top module: `eecfg_loader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `done`, `valid` and `amber_en` are 0, and the config outputs carry the default values.
- R2: A load opens one select window per word, for four words at addresses BASE_ADDR to BASE_ADDR+3 in rising order. Each window sends a start bit 1, then opcode bits 1,0, then a six-bit address, all most significant bit first on rising `ee_sk`, followed by 16 clock pulses for data.
- R3: Returned data is taken most significant bit first. One bit is sampled in the last cycle of each of the 16 data high phases.
- R4: Each `ee_sk` high phase lasts at least HIGH_CYC cycles and each low phase at least LOW_CYC cycles. `ee_di` does not change while `ee_sk` is high.
- R5: `ee_cs` rises at least CSS_CYC cycles before the first rising `ee_sk` of a window. It falls at least CSS_CYC cycles after the last falling `ee_sk`. `ee_sk` is never high while `ee_cs` is low.
- R6: The image layout is as follows. Word 0 is the vendor ID and word 1 is the product ID. Word 2 holds the port count in bits [7:0] and the removable mask in bits [15:8]. Word 3 holds an adjust byte. When the eight bytes sum to 0 modulo 256, `valid` becomes 1 and the config outputs show the loaded fields.
- R7: With a nonzero byte sum, the load still ends with `done` = 1, but `valid` = 0 and the config outputs show the defaults.
- R8: When every sampled data bit is 1, the EEPROM is treated as absent: `valid` = 0, the defaults apply, and `amber_en` = 1 after `done`.
- R9: `amber_en` is 0 during a load, and stays 0 after a load in which any data bit read 0, whether or not the checksum passed.
- R10: A `start` pulse during a load is ignored. A `start` pulse after `done` begins a new load, and `done` reads 0 one cycle later.
- R11: `done` is 0 while a load runs. It rises when the fourth window's gap ends and holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle load request |
| ee_do | input | 1 | EEPROM serial data out |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data in |
| cfg_vid | output | 16 | Vendor ID in effect |
| cfg_pid | output | 16 | Product ID in effect |
| cfg_nports | output | 8 | Downstream port count in effect |
| cfg_rmask | output | 8 | Removable-device mask in effect |
| done | output | 1 | Load finished |
| valid | output | 1 | Loaded image accepted |
| amber_en | output | 1 | Amber LED drive permitted |

## Verification
A behavioural EEPROM answers the frames and compares each command and address with the expected sequence. The bench tries four kinds of image:
- An image whose vendor field is bit-symmetric and whose product field is not. Comparing the two separates bit-order errors from word-order errors.
- An alternating-bit image, which exposes off-by-one sampling.
- A correctly framed image with one flipped checksum bit, which separates checksum rejection from framing faults.
- A data line held high throughout, which separates the absent case (amber allowed) from the bad-checksum case (amber blocked).

A start pulse issued in mid-load and a restart after completion confirm that the state machine only accepts `start` in `ST_IDLE`.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL_SETUP,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_SEL_HOLD,
        ST_SEL_GAP
    } ld_state_t;

    localparam int WORDS_PER_IMAGE = 4;
    localparam int STORED_WORDS    = 3;
    localparam int CMD_BITS        = 9;
    localparam int DATA_BITS       = 16;
    localparam int FRAME_BITS      = CMD_BITS + DATA_BITS;
    localparam int BIT_IDX_W       = $clog2(FRAME_BITS);
    localparam int WORD_IDX_W      = $clog2(WORDS_PER_IMAGE);
    localparam int ADDR_W          = 6;

    // start bit followed by the two-bit read opcode
    localparam logic [2:0] READ_PREFIX = 3'b110;

    typedef struct packed {
        logic [15:0] vid;
        logic [15:0] pid;
        logic [7:0]  nports;
        logic [7:0]  rmask;
    } hub_cfg_t;

endpackage

// File: rtl/eecfg_phase_timer.sv
module eecfg_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R4: a running phase counts down one step per cycle
    a_r4_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/eecfg_cmd_source.sv
module eecfg_cmd_source
    import eecfg_pkg::*;
(
    input  logic [BIT_IDX_W-1:0] bit_idx,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 in_cmd,
    output logic                 cmd_bit
);

    logic [CMD_BITS-1:0] frame;
    logic [3:0]          pick;

    assign frame  = {READ_PREFIX, addr};
    assign in_cmd = (bit_idx < BIT_IDX_W'(CMD_BITS));
    assign pick   = 4'(CMD_BITS - 1) - bit_idx[3:0];

    always_comb begin
        cmd_bit = 1'b0;
        if (in_cmd) begin
            cmd_bit = frame[pick];
        end
    end

endmodule

// File: rtl/eecfg_image_collector.sv
module eecfg_image_collector
    import eecfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  sample,
    input  logic                  sample_bit,
    input  logic                  word_end,
    input  logic [WORD_IDX_W-1:0] word_sel,
    output hub_cfg_t              image,
    output logic                  sum_zero,
    output logic                  all_ones
);

    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] shift_nxt;
    logic [7:0]           sum_q;
    logic [DATA_BITS-1:0] word_q [STORED_WORDS];

    assign shift_nxt = {shift_q[DATA_BITS-2:0], sample_bit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= '0;
            sum_q    <= '0;
            all_ones <= 1'b1;
        end else if (clear) begin
            shift_q  <= '0;
            sum_q    <= '0;
            all_ones <= 1'b1;
        end else if (sample) begin
            shift_q  <= shift_nxt;
            all_ones <= all_ones & sample_bit;
            if (word_end) begin
                sum_q <= sum_q + shift_nxt[15:8] + shift_nxt[7:0];
            end
        end
    end

    for (genvar gi = 0; gi < STORED_WORDS; gi++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[gi] <= '0;
            end else if (clear) begin
                word_q[gi] <= '0;
            end else if (sample && word_end && (word_sel == WORD_IDX_W'(gi))) begin
                word_q[gi] <= shift_nxt;
            end
        end
    end

    assign image.vid    = word_q[0];
    assign image.pid    = word_q[1];
    assign image.nports = word_q[2][7:0];
    assign image.rmask  = word_q[2][15:8];
    assign sum_zero     = (sum_q == 8'h00);

    // R8: a single low bit marks the part as present until the next load
    a_r8_ones_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !all_ones) |=> !all_ones);

    // R3: shift register only moves on a sample
    a_r3_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !sample) |=> $stable(shift_q));

endmodule

// File: rtl/eecfg_loader.sv
module eecfg_loader
    import eecfg_pkg::*;
#(
    parameter int          LOW_CYC    = 36,
    parameter int          HIGH_CYC   = 36,
    parameter int          CSS_CYC    = 36,
    parameter int          GAP_CYC    = 12,
    parameter logic [5:0]  BASE_ADDR  = 6'h00,
    parameter logic [15:0] DEF_VID    = 16'hC0DE,
    parameter logic [15:0] DEF_PID    = 16'h0610,
    parameter logic [7:0]  DEF_NPORTS = 8'd4,
    parameter logic [7:0]  DEF_RMASK  = 8'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        ee_do,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    output logic [15:0] cfg_vid,
    output logic [15:0] cfg_pid,
    output logic [7:0]  cfg_nports,
    output logic [7:0]  cfg_rmask,
    output logic        done,
    output logic        valid,
    output logic        amber_en
);

    localparam int MAX_AB  = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int MAX_CG  = (CSS_CYC > GAP_CYC) ? CSS_CYC : GAP_CYC;
    localparam int TMR_MAX = (MAX_AB > MAX_CG) ? MAX_AB : MAX_CG;
    localparam int TW      = $clog2(TMR_MAX + 1);
    localparam logic [TW-1:0] LOW_LD  = TW'(LOW_CYC - 1);
    localparam logic [TW-1:0] HIGH_LD = TW'(HIGH_CYC - 1);
    localparam logic [TW-1:0] CSS_LD  = TW'(CSS_CYC - 1);
    localparam logic [TW-1:0] GAP_LD  = TW'(GAP_CYC - 1);
    localparam logic [BIT_IDX_W-1:0]  LAST_BIT  = BIT_IDX_W'(FRAME_BITS - 1);
    localparam logic [WORD_IDX_W-1:0] LAST_WORD = WORD_IDX_W'(WORDS_PER_IMAGE - 1);

    ld_state_t state_q, state_nxt;

    logic [BIT_IDX_W-1:0]  bit_idx_q;
    logic [WORD_IDX_W-1:0] word_idx_q;
    logic                  done_q, valid_q, absent_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          begin_load, bit_step, word_step, finish;
    logic          sample_en, word_end;
    logic          in_cmd, cmd_bit;
    logic [ADDR_W-1:0] rd_addr;
    hub_cfg_t      image;
    logic          sum_zero, all_ones;

    eecfg_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    assign rd_addr = BASE_ADDR + ADDR_W'(word_idx_q);

    eecfg_cmd_source u_cmd (
        .bit_idx (bit_idx_q),
        .addr    (rd_addr),
        .in_cmd  (in_cmd),
        .cmd_bit (cmd_bit)
    );

    assign sample_en = (state_q == ST_BIT_HIGH) && tmr_exp && !in_cmd;
    assign word_end  = (bit_idx_q == LAST_BIT);

    eecfg_image_collector u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (begin_load),
        .sample     (sample_en),
        .sample_bit (ee_do),
        .word_end   (word_end),
        .word_sel   (word_idx_q),
        .image      (image),
        .sum_zero   (sum_zero),
        .all_ones   (all_ones)
    );

    // next-state and phase timing
    always_comb begin
        state_nxt  = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        begin_load = 1'b0;
        bit_step   = 1'b0;
        word_step  = 1'b0;
        finish     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_nxt  = ST_SEL_SETUP;
                    tmr_load   = 1'b1;
                    tmr_val    = CSS_LD;
                    begin_load = 1'b1;
                end
            end
            ST_SEL_SETUP: begin
                if (tmr_exp) begin
                    state_nxt = ST_BIT_LOW;
                    tmr_load  = 1'b1;
                    tmr_val   = LOW_LD;
                end
            end
            ST_BIT_LOW: begin
                if (tmr_exp) begin
                    state_nxt = ST_BIT_HIGH;
                    tmr_load  = 1'b1;
                    tmr_val   = HIGH_LD;
                end
            end
            ST_BIT_HIGH: begin
                if (tmr_exp) begin
                    bit_step = 1'b1;
                    tmr_load = 1'b1;
                    if (bit_idx_q == LAST_BIT) begin
                        state_nxt = ST_SEL_HOLD;
                        tmr_val   = CSS_LD;
                    end else begin
                        state_nxt = ST_BIT_LOW;
                        tmr_val   = LOW_LD;
                    end
                end
            end
            ST_SEL_HOLD: begin
                if (tmr_exp) begin
                    state_nxt = ST_SEL_GAP;
                    tmr_load  = 1'b1;
                    tmr_val   = GAP_LD;
                end
            end
            ST_SEL_GAP: begin
                if (tmr_exp) begin
                    if (word_idx_q == LAST_WORD) begin
                        state_nxt = ST_IDLE;
                        finish    = 1'b1;
                    end else begin
                        state_nxt = ST_SEL_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = CSS_LD;
                        word_step = 1'b1;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register and load bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bit_idx_q  <= '0;
            word_idx_q <= '0;
            done_q     <= 1'b0;
            valid_q    <= 1'b0;
            absent_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (begin_load) begin
                bit_idx_q  <= '0;
                word_idx_q <= '0;
                done_q     <= 1'b0;
                valid_q    <= 1'b0;
                absent_q   <= 1'b0;
            end
            if (bit_step) begin
                bit_idx_q <= (bit_idx_q == LAST_BIT) ? '0 : bit_idx_q + 1'b1;
            end
            if (word_step) begin
                word_idx_q <= word_idx_q + 1'b1;
            end
            if (finish) begin
                done_q   <= 1'b1;
                valid_q  <= !all_ones && sum_zero;
                absent_q <= all_ones;
            end
        end
    end

    // outputs
    always_comb begin
        ee_cs = 1'b0;
        ee_sk = 1'b0;
        ee_di = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_SEL_SETUP: ee_cs = 1'b1;
            ST_BIT_LOW: begin
                ee_cs = 1'b1;
                ee_di = cmd_bit;
            end
            ST_BIT_HIGH: begin
                ee_cs = 1'b1;
                ee_sk = 1'b1;
                ee_di = cmd_bit;
            end
            ST_SEL_HOLD:  ee_cs = 1'b1;
            ST_SEL_GAP:   ;
            default:      ;
        endcase
        done       = done_q;
        valid      = valid_q;
        amber_en   = done_q && absent_q;
        cfg_vid    = valid_q ? image.vid    : DEF_VID;
        cfg_pid    = valid_q ? image.pid    : DEF_PID;
        cfg_nports = valid_q ? image.nports : DEF_NPORTS;
        cfg_rmask  = valid_q ? image.rmask  : DEF_RMASK;
    end

    // ---------------- interface timing checks ----------------
    logic [15:0] hi_run, lo_run, cs_run, post_sk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run  <= '0;
            lo_run  <= '0;
            cs_run  <= '0;
            post_sk <= '0;
        end else begin
            hi_run  <= ee_sk ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
            lo_run  <= ee_sk ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
            cs_run  <= ee_cs ? ((cs_run == 16'hFFFF) ? cs_run : cs_run + 1'b1) : '0;
            post_sk <= ee_sk ? '0 : ((post_sk == 16'hFFFF) ? post_sk : post_sk + 1'b1);
        end
    end

    a_r4_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk) |-> (hi_run >= 16'(HIGH_CYC)));

    a_r4_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> (lo_run >= 16'(LOW_CYC)));

    a_r4_di_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> $stable(ee_di));

    a_r5_cs_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> (cs_run >= 16'(CSS_CYC)));

    a_r5_cs_trail: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> (post_sk >= 16'(CSS_CYC)));

    a_r5_no_stray_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    a_r9_amber_gate: assert property (@(posedge clk) disable iff (!rst_n)
        amber_en |-> (done && !valid));

    a_r11_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> done);

    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cs && start) |=> !done);

endmodule

// File: tb/eecfg_loader_bench.sv
`timescale 1ns/1ps
module eecfg_loader_bench;

    localparam int LOW_C  = 36;
    localparam int HIGH_C = 36;
    localparam int CSS_C  = 36;
    localparam logic [15:0] D_VID = 16'hC0DE;
    localparam logic [15:0] D_PID = 16'h0610;
    localparam logic [7:0]  D_NP  = 8'd4;
    localparam logic [7:0]  D_RM  = 8'h00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ee_do;
    logic ee_cs, ee_sk, ee_di;
    logic [15:0] cfg_vid, cfg_pid;
    logic [7:0]  cfg_nports, cfg_rmask;
    logic done, valid, amber_en;

    always #10 clk = ~clk;

    eecfg_loader u_eecfg_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .ee_do(ee_do),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .cfg_vid(cfg_vid), .cfg_pid(cfg_pid), .cfg_nports(cfg_nports),
        .cfg_rmask(cfg_rmask), .done(done), .valid(valid), .amber_en(amber_en)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural EEPROM ----------------
    logic [15:0] mem [4];
    bit   present = 1'b1;
    logic do_r = 1'b0;
    int   edge_n = 0;
    logic [8:0] cmd_sh = '0;
    logic [5:0] cur_addr = '0;
    int   addr_exp = 0;
    int   win_cnt = 0;
    int   cmd_err = 0;

    assign ee_do = present ? do_r : 1'b1;

    always @(posedge ee_cs) edge_n = 0;
    always @(negedge ee_cs) do_r = 1'b0;

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            edge_n++;
            if (edge_n <= 9) cmd_sh = {cmd_sh[7:0], ee_di};
            if (edge_n == 9) begin
                if (cmd_sh[8:6] != 3'b110 || cmd_sh[5:0] != 6'(addr_exp)) cmd_err++;
                cur_addr = cmd_sh[5:0];
                addr_exp++;
                win_cnt++;
            end
            if (edge_n >= 10 && edge_n <= 25) do_r = mem[cur_addr[1:0]][25 - edge_n];
            if (edge_n > 25) cmd_err++;
        end
    end

    // ---------------- timing monitor (R4, R5) ----------------
    int hi_run = 0, lo_run = 0, cs_run = 0, post_sk = 0, tim_err = 0;
    logic sk_p = 1'b0, cs_p = 1'b0, di_p = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ee_sk && !sk_p && lo_run < LOW_C) tim_err++;
            if (ee_sk && !sk_p && cs_run < CSS_C) tim_err++;
            if (!ee_sk && sk_p && hi_run < HIGH_C) tim_err++;
            if (!ee_cs && cs_p && post_sk < CSS_C) tim_err++;
            if (ee_sk && ee_di != di_p) tim_err++;
            if (ee_sk && !ee_cs) tim_err++;
        end
        hi_run  = ee_sk ? hi_run + 1 : 0;
        lo_run  = ee_sk ? 0 : lo_run + 1;
        cs_run  = ee_cs ? cs_run + 1 : 0;
        post_sk = ee_sk ? 0 : post_sk + 1;
        sk_p = ee_sk; cs_p = ee_cs; di_p = ee_di;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0] vid;
        logic [15:0] pid;
        logic [7:0]  np;
        logic [7:0]  rm;
        logic        vld;
        logic        amb;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    logic done_q = 1'b0;

    always @(negedge clk) begin
        if (rst_n && done && !done_q) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", "unexpected done", 64'(done), 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(valid == e.vld, e.req, "valid", 64'(valid), 64'(e.vld));
                chk(amber_en == e.amb, e.req, "amber_en", 64'(amber_en), 64'(e.amb));
                chk(cfg_vid == e.vid, e.req, "vid (R3)", 64'(cfg_vid), 64'(e.vid));
                chk(cfg_pid == e.pid, e.req, "pid (R3)", 64'(cfg_pid), 64'(e.pid));
                chk({cfg_rmask, cfg_nports} == {e.rm, e.np}, e.req, "ports/mask",
                    64'({cfg_rmask, cfg_nports}), 64'({e.rm, e.np}));
            end
        end
        done_q = done;
    end

    // ---------------- driver ----------------
    task automatic run_load(input logic [15:0] vid, input logic [15:0] pid,
                            input logic [7:0] np, input logic [7:0] rm,
                            input bit fitted, input bit corrupt, input bit poke_busy);
        logic [7:0] adj;
        exp_t e;
        int n;
        adj = 8'h00 - (vid[15:8] + vid[7:0] + pid[15:8] + pid[7:0] + np + rm);
        mem[0] = vid;
        mem[1] = pid;
        mem[2] = {rm, np};
        mem[3] = {8'h00, adj} ^ (corrupt ? 16'h0001 : 16'h0000);
        present = fitted;
        e.vld = fitted && !corrupt;
        e.amb = !fitted;
        e.vid = e.vld ? vid : D_VID;
        e.pid = e.vld ? pid : D_PID;
        e.np  = e.vld ? np  : D_NP;
        e.rm  = e.vld ? rm  : D_RM;
        e.req = !fitted ? "R8" : (corrupt ? "R7" : "R6");
        exp_q.push_back(e);
        win_cnt = 0; cmd_err = 0; addr_exp = 0; tim_err = 0;

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0, "R10", "done after start", 64'(done), 64'h0);
        repeat (200) @(negedge clk);
        chk(done == 1'b0 && amber_en == 1'b0 && valid == 1'b0, "R9",
            "mid-load done/amber/valid", 64'({done, amber_en, valid}), 64'h0);
        if (poke_busy) begin
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R11", "done reached", 64'(done), 64'h1);
        chk(win_cnt == 4, poke_busy ? "R10" : "R2", "select windows",
            64'(win_cnt), 64'd4);
        chk(cmd_err == 0, "R2", "command/address errors", 64'(cmd_err), 64'h0);
        chk(tim_err == 0, "R4", "timing violations (R5)", 64'(tim_err), 64'h0);
        repeat (50) @(negedge clk);
        chk(done == 1'b1, "R11", "done holds", 64'(done), 64'h1);
        chk(amber_en == !fitted, "R9", "amber after load", 64'(amber_en), 64'(!fitted));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            chk(exp_q.size() == 0, "R11", "pending results", 64'(exp_q.size()), 64'h0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({ee_cs, ee_sk, ee_di, done, valid, amber_en} == 6'b0, "R1",
            "control outputs in reset", 64'({ee_cs, ee_sk, ee_di, done, valid, amber_en}), 64'h0);
        chk({cfg_vid, cfg_pid, cfg_nports, cfg_rmask} == {D_VID, D_PID, D_NP, D_RM}, "R1",
            "defaults in reset", 64'({cfg_vid, cfg_pid, cfg_nports, cfg_rmask}),
            64'({D_VID, D_PID, D_NP, D_RM}));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({ee_cs, done} == 2'b0, "R1", "idle after reset", 64'({ee_cs, done}), 64'h0);

        run_load(16'h8001, 16'h1234, 8'd3, 8'h04, 1'b1, 1'b0, 1'b0); // R6, R3
        run_load(16'hA5A5, 16'h5A5A, 8'd2, 8'h02, 1'b1, 1'b0, 1'b1); // R3, R10 busy start
        run_load(16'h4321, 16'h00F0, 8'd4, 8'h0C, 1'b1, 1'b1, 1'b0); // R7, R9
        run_load(16'h1111, 16'h2222, 8'd1, 8'h01, 1'b0, 1'b0, 1'b0); // R8
        run_load(16'h0E0F, 16'hF0E0, 8'd4, 8'h08, 1'b1, 1'b0, 1'b0); // R10 restart
        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R11", "watchdog expired", 64'h0, 64'h1);
            finish_run();
        end
    end

endmodule